// File: doc/BRIEF.md
# Processor Debug Breakpoint Unit

This block gives a 32-bit processor one instruction breakpoint and one data watchpoint. Software sets it up with coprocessor-style register accesses. Each access names a register with a 3-bit secondary opcode field and a 4-bit register-select field. Once set up, the unit watches three buses: the load bus, the store bus and the instruction fetch bus. When an access matches, it raises a one-cycle event pulse, and the processor turns that pulse into a debug exception.

The data watchpoint has one address, one comparison value and one don't-care mask. Three modes share that set, and each mode has its own enable bit in a small control register:

- Load watch compares the masked load address.
- Store-address watch compares the masked store address.
- Store-data watch compares the masked store data, and ignores the address.

The instruction breakpoint is a single write-only word. Bit 0 of the word arms or disarms the breakpoint. Bits 31:2 give the fetch address to compare against.

Each pulse is registered. It appears in the cycle after the bus access that caused it. A register read returns its data combinationally, in the same cycle as the select inputs.

Top module: `dbg_break_unit`

## Requirements
- R1: After reset, all four event outputs are 0. Reads of the address, value, mask and control registers return 0. No breakpoint is armed.
- R2: With opcode field 0b000, a write takes effect on the next clock edge, and the written value reads back in full at these selects: 0b0000 for the watch address, 0b0001 for the watch value, 0b0010 for the watch mask.
- R3: The control register (opcode 0b000, select 0b0011) stores only write-data bits 2:0. Bits 31:3 always read as 0.
- R4: When control bit 0 is set, a valid load whose masked address equals the masked watch address drives `ld_hit_o` high for exactly the next cycle.
- R5: When control bit 1 is set, a valid store whose masked address equals the masked watch address drives `st_addr_hit_o` high for exactly the next cycle.
- R6: When control bit 2 is set, a valid store whose masked data equals the masked watch value drives `st_data_hit_o` high for exactly the next cycle, whatever the store address.
- R7: A 1 in a mask bit removes that bit from both the address compare and the data compare.
- R8: The instruction breakpoint word sits at opcode 0b000, select 0b1000, and always reads as 0. Writing it with bit 0 = 1 arms the breakpoint. Writing it with bit 0 = 0 disarms it. When armed, a valid fetch at a matching address drives `ibrk_hit_o` high for exactly the next cycle.
- R9: The fetch compare uses only bits 31:2. Bit 1 of the written word and fetch-address bits 1:0 have no effect.
- R10: Any opcode/select pair not listed above reads as 0, and writing it changes no register and no breakpoint behaviour.
- R11: A mode whose control bit is 0 never raises its pulse, even when its compare matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cfg_wr_i | input | 1 | Register write strobe |
| cfg_op2_i | input | 3 | Secondary opcode field |
| cfg_crm_i | input | 4 | Register select field |
| cfg_wdata_i | input | 32 | Write data |
| cfg_rdata_o | output | 32 | Read data for the current select (combinational) |
| ld_valid_i | input | 1 | Load access valid |
| ld_addr_i | input | 32 | Load address |
| st_valid_i | input | 1 | Store access valid |
| st_addr_i | input | 32 | Store address |
| st_data_i | input | 32 | Store data |
| if_valid_i | input | 1 | Instruction fetch valid |
| if_addr_i | input | 32 | Fetch address |
| ld_hit_o | output | 1 | Load watch event pulse |
| st_addr_hit_o | output | 1 | Store-address watch event pulse |
| st_data_hit_o | output | 1 | Store-data watch event pulse |
| ibrk_hit_o | output | 1 | Instruction breakpoint event pulse |

## Verification
The bench checks that every pulse drops after one cycle. A design that latched its match would hold the pulse through the following idle cycle. It sets the control register to all ones and reads back only the low three bits, so a full-width control register is caught. It sends a store that matches on address but not on data, and a store that matches on data but not on address, to find a design whose three modes interfere. It fetches with bit 1 set against a word written with bit 1 set, and also disarms through bit 0, so a design that compares bit 1 or ignores the enable gives the wrong pulse. It writes through unlisted selects and through a non-zero opcode, and then reads and uses the real registers, which exposes loose decoding.

// File: rtl/dbg_break_pkg.sv
`timescale 1ns/1ps
package dbg_break_pkg;
    localparam int XLEN  = 32;
    localparam int OP2_W = 3;
    localparam int CRM_W = 4;
    localparam int CTL_W = 3;

    localparam logic [OP2_W-1:0] OP2_BRK  = 3'b000;
    localparam logic [CRM_W-1:0] SEL_WADR = 4'b0000;
    localparam logic [CRM_W-1:0] SEL_WVAL = 4'b0001;
    localparam logic [CRM_W-1:0] SEL_WMSK = 4'b0010;
    localparam logic [CRM_W-1:0] SEL_WCTL = 4'b0011;
    localparam logic [CRM_W-1:0] SEL_IBRK = 4'b1000;

    localparam int CTL_LD = 0;
    localparam int CTL_SA = 1;
    localparam int CTL_SD = 2;

    typedef struct packed {
        logic [XLEN-1:0]  wadr;
        logic [XLEN-1:0]  wval;
        logic [XLEN-1:0]  wmsk;
        logic [CTL_W-1:0] wctl;
        logic [XLEN-1:0]  iadr;
        logic             iarm;
    } brk_regs_t;

    typedef struct packed {
        logic ld;
        logic sa;
        logic sd;
    } data_hits_t;

    function automatic logic masked_eq(input logic [XLEN-1:0] a,
                                       input logic [XLEN-1:0] b,
                                       input logic [XLEN-1:0] dc);
        return ((a ^ b) & ~dc) == '0;
    endfunction
endpackage

// File: rtl/dbg_break_regs.sv
`timescale 1ns/1ps
module dbg_break_regs
    import dbg_break_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_i,
    input  logic [OP2_W-1:0] op2_i,
    input  logic [CRM_W-1:0] crm_i,
    input  logic [XLEN-1:0]  wdata_i,
    output logic [XLEN-1:0]  rdata_o,
    output brk_regs_t        regs_o
);
    localparam int ALIGN_BITS = 2;

    brk_regs_t regs_d, regs_q;
    logic      sel_ok;

    assign sel_ok = (op2_i == OP2_BRK);

    always_comb begin
        regs_d = regs_q;
        if (wr_i && sel_ok) begin
            unique case (crm_i)
                SEL_WADR: regs_d.wadr = wdata_i;
                SEL_WVAL: regs_d.wval = wdata_i;
                SEL_WMSK: regs_d.wmsk = wdata_i;
                SEL_WCTL: regs_d.wctl = wdata_i[CTL_W-1:0];
                SEL_IBRK: begin
                    regs_d.iadr = {wdata_i[XLEN-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
                    regs_d.iarm = wdata_i[0];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) regs_q <= '0;
        else         regs_q <= regs_d;
    end

    always_comb begin
        rdata_o = '0;
        if (sel_ok) begin
            unique case (crm_i)
                SEL_WADR: rdata_o = regs_q.wadr;
                SEL_WVAL: rdata_o = regs_q.wval;
                SEL_WMSK: rdata_o = regs_q.wmsk;
                SEL_WCTL: rdata_o = {{(XLEN-CTL_W){1'b0}}, regs_q.wctl};
                default:  rdata_o = '0;
            endcase
        end
    end

    assign regs_o = regs_q;
endmodule

// File: rtl/dbg_data_watch.sv
`timescale 1ns/1ps
module dbg_data_watch
    import dbg_break_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [XLEN-1:0]  wadr_i,
    input  logic [XLEN-1:0]  wval_i,
    input  logic [XLEN-1:0]  wmsk_i,
    input  logic [CTL_W-1:0] wctl_i,
    input  logic             ld_valid_i,
    input  logic [XLEN-1:0]  ld_addr_i,
    input  logic             st_valid_i,
    input  logic [XLEN-1:0]  st_addr_i,
    input  logic [XLEN-1:0]  st_data_i,
    output data_hits_t       hits_o
);
    data_hits_t hits_d, hits_q;

    always_comb begin
        hits_d    = '0;
        hits_d.ld = wctl_i[CTL_LD] && ld_valid_i && masked_eq(ld_addr_i, wadr_i, wmsk_i);
        hits_d.sa = wctl_i[CTL_SA] && st_valid_i && masked_eq(st_addr_i, wadr_i, wmsk_i);
        hits_d.sd = wctl_i[CTL_SD] && st_valid_i && masked_eq(st_data_i, wval_i, wmsk_i);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) hits_q <= '0;
        else         hits_q <= hits_d;
    end

    assign hits_o = hits_q;
endmodule

// File: rtl/dbg_insn_watch.sv
`timescale 1ns/1ps
module dbg_insn_watch
    import dbg_break_pkg::*;
#(
    parameter int IGNORE_LSBS = 2
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [XLEN-1:0] iadr_i,
    input  logic            iarm_i,
    input  logic            if_valid_i,
    input  logic [XLEN-1:0] if_addr_i,
    output logic            hit_o
);
    localparam logic [XLEN-1:0] LSB_DC = XLEN'((64'd1 << IGNORE_LSBS) - 64'd1);

    logic hit_d, hit_q;

    always_comb begin
        hit_d = iarm_i && if_valid_i && masked_eq(if_addr_i, iadr_i, LSB_DC);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) hit_q <= 1'b0;
        else         hit_q <= hit_d;
    end

    assign hit_o = hit_q;
endmodule

// File: rtl/dbg_break_unit.sv
`timescale 1ns/1ps
module dbg_break_unit
    import dbg_break_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             cfg_wr_i,
    input  logic [OP2_W-1:0] cfg_op2_i,
    input  logic [CRM_W-1:0] cfg_crm_i,
    input  logic [XLEN-1:0]  cfg_wdata_i,
    output logic [XLEN-1:0]  cfg_rdata_o,
    input  logic             ld_valid_i,
    input  logic [XLEN-1:0]  ld_addr_i,
    input  logic             st_valid_i,
    input  logic [XLEN-1:0]  st_addr_i,
    input  logic [XLEN-1:0]  st_data_i,
    input  logic             if_valid_i,
    input  logic [XLEN-1:0]  if_addr_i,
    output logic             ld_hit_o,
    output logic             st_addr_hit_o,
    output logic             st_data_hit_o,
    output logic             ibrk_hit_o
);
    brk_regs_t        regs_w;
    data_hits_t       dhits_w;
    logic [CTL_W-1:0] ctl_w;
    logic             iarm_w;

    dbg_break_regs u_regs (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_i    (cfg_wr_i),
        .op2_i   (cfg_op2_i),
        .crm_i   (cfg_crm_i),
        .wdata_i (cfg_wdata_i),
        .rdata_o (cfg_rdata_o),
        .regs_o  (regs_w)
    );

    dbg_data_watch u_dwatch (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wadr_i     (regs_w.wadr),
        .wval_i     (regs_w.wval),
        .wmsk_i     (regs_w.wmsk),
        .wctl_i     (regs_w.wctl),
        .ld_valid_i (ld_valid_i),
        .ld_addr_i  (ld_addr_i),
        .st_valid_i (st_valid_i),
        .st_addr_i  (st_addr_i),
        .st_data_i  (st_data_i),
        .hits_o     (dhits_w)
    );

    dbg_insn_watch #(.IGNORE_LSBS(2)) u_iwatch (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .iadr_i     (regs_w.iadr),
        .iarm_i     (regs_w.iarm),
        .if_valid_i (if_valid_i),
        .if_addr_i  (if_addr_i),
        .hit_o      (ibrk_hit_o)
    );

    assign ctl_w         = regs_w.wctl;
    assign iarm_w        = regs_w.iarm;
    assign ld_hit_o      = dhits_w.ld;
    assign st_addr_hit_o = dhits_w.sa;
    assign st_data_hit_o = dhits_w.sd;
endmodule

// File: rtl/dbg_break_chk.sv
`timescale 1ns/1ps
module dbg_break_chk
    import dbg_break_pkg::*;
(
    input logic             clk_i,
    input logic             rst_ni,
    input logic [OP2_W-1:0] cfg_op2_i,
    input logic [CRM_W-1:0] cfg_crm_i,
    input logic [XLEN-1:0]  cfg_rdata_o,
    input logic             ld_valid_i,
    input logic             st_valid_i,
    input logic             if_valid_i,
    input logic             ld_hit_o,
    input logic             st_addr_hit_o,
    input logic             st_data_hit_o,
    input logic             ibrk_hit_o,
    input logic [CTL_W-1:0] ctl_q,
    input logic             iarm_q
);
    AST_LD_HIT_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ld_hit_o |-> $past(ld_valid_i && ctl_q[CTL_LD])); // R4
    AST_SA_HIT_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_addr_hit_o |-> $past(st_valid_i && ctl_q[CTL_SA])); // R5
    AST_SD_HIT_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_data_hit_o |-> $past(st_valid_i && ctl_q[CTL_SD])); // R6
    AST_IBRK_HIT_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ibrk_hit_o |-> $past(if_valid_i && iarm_q)); // R8
    AST_CTL_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_op2_i == OP2_BRK && cfg_crm_i == SEL_WCTL) |-> cfg_rdata_o[XLEN-1:CTL_W] == '0); // R3
    AST_IBRK_UNREADABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_crm_i == SEL_IBRK) |-> cfg_rdata_o == '0); // R8
    AST_FOREIGN_OP2_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_op2_i != OP2_BRK) |-> cfg_rdata_o == '0); // R10
endmodule

bind dbg_break_unit dbg_break_chk u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cfg_op2_i     (cfg_op2_i),
    .cfg_crm_i     (cfg_crm_i),
    .cfg_rdata_o   (cfg_rdata_o),
    .ld_valid_i    (ld_valid_i),
    .st_valid_i    (st_valid_i),
    .if_valid_i    (if_valid_i),
    .ld_hit_o      (ld_hit_o),
    .st_addr_hit_o (st_addr_hit_o),
    .st_data_hit_o (st_data_hit_o),
    .ibrk_hit_o    (ibrk_hit_o),
    .ctl_q         (ctl_w),
    .iarm_q        (iarm_w)
);

// File: tb/dbg_break_unit_tb_top.sv
`timescale 1ns/1ps
module dbg_break_unit_tb_top;
    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        cfg_wr_i = 1'b0;
    logic [2:0]  cfg_op2_i = '0;
    logic [3:0]  cfg_crm_i = '0;
    logic [31:0] cfg_wdata_i = '0;
    logic [31:0] cfg_rdata_o;
    logic        ld_valid_i = 1'b0;
    logic [31:0] ld_addr_i = '0;
    logic        st_valid_i = 1'b0;
    logic [31:0] st_addr_i = '0;
    logic [31:0] st_data_i = '0;
    logic        if_valid_i = 1'b0;
    logic [31:0] if_addr_i = '0;
    logic        ld_hit_o, st_addr_hit_o, st_data_hit_o, ibrk_hit_o;

    always #2 clk_i = ~clk_i;

    dbg_break_unit dut_i (.*);

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    logic [31:0] m_adr = '0, m_val = '0, m_msk = '0, m_iadr = '0;
    logic [2:0]  m_ctl = '0;
    logic        m_arm = 1'b0;

    typedef struct {
        logic [3:0] exp;
        string      tag;
    } sb_item_t;
    sb_item_t sb_q[$];

    task automatic check32(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [2:0] op2, input logic [3:0] crm, input logic [31:0] d);
        @(negedge clk_i);
        cfg_wr_i = 1'b1; cfg_op2_i = op2; cfg_crm_i = crm; cfg_wdata_i = d;
        @(negedge clk_i);
        cfg_wr_i = 1'b0; cfg_op2_i = '0; cfg_crm_i = '0; cfg_wdata_i = '0;
        if (op2 == 3'b000) begin
            case (crm)
                4'b0000: m_adr = d;
                4'b0001: m_val = d;
                4'b0010: m_msk = d;
                4'b0011: m_ctl = d[2:0];
                4'b1000: begin m_iadr = {d[31:2], 2'b00}; m_arm = d[0]; end
                default: ;
            endcase
        end
    endtask

    task automatic cfg_read(input logic [2:0] op2, input logic [3:0] crm,
                            input logic [31:0] exp, input string tag);
        @(negedge clk_i);
        cfg_op2_i = op2; cfg_crm_i = crm;
        #1 check32(cfg_rdata_o, exp, tag);
        cfg_op2_i = '0; cfg_crm_i = '0;
    endtask

    function automatic logic meq(input logic [31:0] a, input logic [31:0] b, input logic [31:0] dc);
        return ((a ^ b) & ~dc) == 32'h0;
    endfunction

    // One access cycle, then one idle cycle; expectations go to the scoreboard.
    task automatic bus_cycle(input logic lv, input logic [31:0] la,
                             input logic sv, input logic [31:0] sa, input logic [31:0] sd,
                             input logic iv, input logic [31:0] ia, input string tag);
        sb_item_t it;
        @(negedge clk_i);
        ld_valid_i = lv; ld_addr_i = la;
        st_valid_i = sv; st_addr_i = sa; st_data_i = sd;
        if_valid_i = iv; if_addr_i = ia;
        it.exp[0] = m_ctl[0] && lv && meq(la, m_adr, m_msk);
        it.exp[1] = m_ctl[1] && sv && meq(sa, m_adr, m_msk);
        it.exp[2] = m_ctl[2] && sv && meq(sd, m_val, m_msk);
        it.exp[3] = m_arm && iv && (ia[31:2] == m_iadr[31:2]);
        it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk_i);
        ld_valid_i = 1'b0; st_valid_i = 1'b0; if_valid_i = 1'b0;
        it.exp = 4'b0000;
        it.tag = {tag, " pulse-end"};
        sb_q.push_back(it);
    endtask

    initial begin : monitor
        forever begin
            @(posedge clk_i);
            #1;
            while (sb_q.size() > 0) begin
                sb_item_t it;
                it = sb_q.pop_front();
                check32({28'h0, ibrk_hit_o, st_data_hit_o, st_addr_hit_o, ld_hit_o},
                        {28'h0, it.exp}, it.tag);
            end
        end
    end

    initial begin : watchdog
        #(4 * 200000);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        #1 check32({28'h0, ibrk_hit_o, st_data_hit_o, st_addr_hit_o, ld_hit_o}, 32'h0, "R1 outputs after reset");
        cfg_read(3'b000, 4'b0000, 32'h0, "R1 watch address reset");
        cfg_read(3'b000, 4'b0001, 32'h0, "R1 watch value reset");
        cfg_read(3'b000, 4'b0010, 32'h0, "R1 watch mask reset");
        cfg_read(3'b000, 4'b0011, 32'h0, "R1 control reset");
        bus_cycle(1, 32'h0, 1, 32'h0, 32'h0, 1, 32'h0, "R1 nothing armed at reset");

        cfg_write(3'b000, 4'b0000, 32'h1000_0040);
        cfg_write(3'b000, 4'b0001, 32'hCAFE_0000);
        cfg_write(3'b000, 4'b0010, 32'h0);
        cfg_read(3'b000, 4'b0000, 32'h1000_0040, "R2 watch address readback");
        cfg_read(3'b000, 4'b0001, 32'hCAFE_0000, "R2 watch value readback");
        cfg_read(3'b000, 4'b0010, 32'h0, "R2 watch mask readback");

        cfg_write(3'b000, 4'b0011, 32'hFFFF_FFFF);
        cfg_read(3'b000, 4'b0011, 32'h0000_0007, "R3 control keeps bits 2:0 only");

        cfg_write(3'b000, 4'b0011, 32'h0);
        bus_cycle(1, 32'h1000_0040, 1, 32'h1000_0040, 32'hCAFE_0000, 0, 32'h0, "R11 all modes off");

        cfg_write(3'b000, 4'b0011, 32'h1);
        bus_cycle(1, 32'h1000_0040, 0, 32'h0, 32'h0, 0, 32'h0, "R4 load watch hit");
        bus_cycle(1, 32'h1000_0044, 0, 32'h0, 32'h0, 0, 32'h0, "R4 load other address");
        bus_cycle(0, 32'h0, 1, 32'h1000_0040, 32'hCAFE_0000, 0, 32'h0, "R11 store with only load watch");

        cfg_write(3'b000, 4'b0010, 32'h0000_000F);
        bus_cycle(1, 32'h1000_0045, 0, 32'h0, 32'h0, 0, 32'h0, "R7 masked low bits ignored");
        bus_cycle(1, 32'h1000_0050, 0, 32'h0, 32'h0, 0, 32'h0, "R7 unmasked bit differs");

        cfg_write(3'b000, 4'b0011, 32'h2);
        bus_cycle(0, 32'h0, 1, 32'h1000_004C, 32'h1234_5678, 0, 32'h0, "R5 store address hit");
        bus_cycle(1, 32'h1000_0040, 0, 32'h0, 32'h0, 0, 32'h0, "R11 load with only store-address watch");

        cfg_write(3'b000, 4'b0011, 32'h4);
        bus_cycle(0, 32'h0, 1, 32'h2000_0000, 32'hCAFE_0003, 0, 32'h0, "R6 store data hit other address");
        bus_cycle(0, 32'h0, 1, 32'h1000_0040, 32'hCAFE_0100, 0, 32'h0, "R6 store data miss address match");
        bus_cycle(0, 32'h0, 0, 32'h0, 32'hCAFE_0000, 0, 32'h0, "R6 invalid store ignored");

        cfg_write(3'b000, 4'b0011, 32'h7);
        bus_cycle(1, 32'h1000_0041, 1, 32'h1000_0042, 32'hCAFE_000A, 0, 32'h0, "R4 R5 R6 all modes together");

        cfg_write(3'b000, 4'b1000, 32'h2000_0103);
        cfg_read(3'b000, 4'b1000, 32'h0, "R8 instruction word unreadable");
        bus_cycle(0, 32'h0, 0, 32'h0, 32'h0, 1, 32'h2000_0100, "R8 fetch hit when armed");
        bus_cycle(0, 32'h0, 0, 32'h0, 32'h0, 1, 32'h2000_0103, "R9 low fetch bits ignored");
        bus_cycle(0, 32'h0, 0, 32'h0, 32'h0, 1, 32'h2000_0104, "R9 bit 2 compared");
        bus_cycle(0, 32'h0, 0, 32'h0, 32'h0, 0, 32'h2000_0100, "R8 invalid fetch ignored");
        cfg_write(3'b000, 4'b1000, 32'h2000_0100);
        bus_cycle(0, 32'h0, 0, 32'h0, 32'h0, 1, 32'h2000_0100, "R8 disarmed by bit 0 clear");

        cfg_write(3'b001, 4'b0000, 32'hDEAD_BEEF);
        cfg_write(3'b000, 4'b0101, 32'hDEAD_BEEF);
        cfg_write(3'b010, 4'b1000, 32'h3000_0001);
        cfg_read(3'b000, 4'b0000, 32'h1000_0040, "R10 watch address untouched");
        cfg_read(3'b000, 4'b0101, 32'h0, "R10 unlisted select reads zero");
        cfg_read(3'b001, 4'b0000, 32'h0, "R10 foreign opcode reads zero");
        bus_cycle(0, 32'h0, 0, 32'h0, 32'h0, 1, 32'h3000_0000, "R10 foreign opcode did not arm");

        @(posedge clk_i);
        #2;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule